// File: doc/BRIEF.md
# Joinable Four-Channel Pulse-Width Modulator

The block produces four active-high, left-aligned PWM waveforms from one system clock. The channels are grouped into two pairs, {0,1} and {2,3}. Each pair runs either as two independent 8-bit PWMs or as one 16-bit PWM. In the 16-bit case the even channel holds the upper byte, the odd channel holds the lower byte, and the waveform appears on the even channel's pin. Software can move a pair between the two arrangements at any time by writing one control register.

A single free-running 7-bit divider produces two enable strobes. Strobe A clocks pair {0,1} and strobe B clocks pair {2,3}. Each strobe runs at the system clock divided by a programmable power of two, so every register stays in one clock domain. New period and duty values go into shadow registers. A channel copies them into its working registers only when its counter wraps, so a period that is already running is never cut short or distorted.

Each pair is governed by a two-state machine:
- `PAIR_SPLIT`: two 8-bit counters run independently.
- `PAIR_JOINED`: one 16-bit counter runs.

The transition `SPLIT_TO_JOINED` is taken when the pair's join bit is read as 1 while the pair is in `PAIR_SPLIT`. The transition `JOINED_TO_SPLIT` is taken when the join bit is read as 0 while the pair is in `PAIR_JOINED`. Both transitions clear the pair's counters and load the working registers from the shadows in the same cycle.

Top module: `pwm4_joinable`

## Requirements
- R1: The register port is as follows.
  - Address 0 is an 8-bit control word. It resets to 0x00 and can be written or read at any time.
  - Bits of the control word: bit 7 joins pair {2,3}, bit 6 joins pair {0,1}, bits 5:3 are divider code A, bits 2:0 are divider code B.
  - Addresses 4+c hold the period of channel c and addresses 8+c hold its duty, for c = 0..3. Each reads back the last value written.
  - Any other address reads as 0.
  - Reads are combinational; a write takes effect at the clock edge where `reg_we` is high.
- R2: Divider code n (0..7) makes the counters of a pair advance once every 2^n system clocks. Code A drives pair {0,1} and code B drives pair {2,3}. Whenever code A is greater than or equal to code B, every A strobe coincides with a B strobe.
- R3: In split mode, a channel with period P and duty D repeats every P+1 counter steps. Its pin is high for min(D, P+1) of those steps.
- R4: A duty of 0 holds the pin low. A duty greater than the period holds the pin high. This applies in both split and joined mode.
- R5: In joined mode, the pair behaves as one PWM. Its 16-bit period is {even-channel period, odd-channel period} and its 16-bit duty is formed the same way. The output appears on the even pin (0 or 2).
- R6: While a pair is joined, its odd pin (1 or 3) stays low.
- R7: A write to a period or duty register does not change the running waveform until the channel's counter (or the pair's 16-bit counter) wraps.
- R8: When a pair's join bit changes, the pair's counters restart from 0 and its working registers load the shadow values at once.
- R9: During reset all four pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pwm_out | output | 4 | PWM pins, bit c is channel c |

## Verification
The bench uses the default parameters: 8-bit channels, 3-bit divider codes and a 7-bit divider. This makes the whole divider range reachable, up to code 7 (a step every 128 clocks). It also makes 16-bit joined periods above 255 reachable within a few thousand cycles, so a carry from the low byte into the high byte actually occurs. Every waveform is measured over a window of exactly two periods. The measured high count therefore does not depend on phase. The bench checks the deferred-load rule by changing the duty in the middle of a long period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int NUM_CH    = 4;
    localparam int NUM_PAIRS = NUM_CH / 2;
    localparam int CTRL_ADDR = 0;
    localparam int PER_BASE  = 4;
    localparam int DUTY_BASE = 8;

    typedef enum logic {
        PAIR_SPLIT  = 1'b0,
        PAIR_JOINED = 1'b1
    } pair_mode_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  ctrl_q,
    output logic [W-1:0]  per_q  [NUM_CH],
    output logic [W-1:0]  duty_q [NUM_CH]
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (we && addr == AW'(CTRL_ADDR))
            ctrl_q <= wdata;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                per_q[c]  <= '0;
                duty_q[c] <= '0;
            end else if (we) begin
                if (addr == AW'(PER_BASE + c))  per_q[c]  <= wdata;
                if (addr == AW'(DUTY_BASE + c)) duty_q[c] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(CTRL_ADDR)) rdata = ctrl_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == AW'(PER_BASE + c))  rdata = per_q[c];
            if (addr == AW'(DUTY_BASE + c)) rdata = duty_q[c];
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == AW'(CTRL_ADDR)) |=> $stable(ctrl_q)); // R1
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    output logic              tick_a,
    output logic              tick_b
);
    localparam int DIV_W = (1 << CODE_W) - 1;

    logic [DIV_W-1:0] div_cnt;

    function automatic logic strobe(input logic [DIV_W-1:0] cnt,
                                    input logic [CODE_W-1:0] code);
        logic [DIV_W-1:0] mask;
        mask = DIV_W'((1 << code) - 1);
        return (cnt & mask) == mask;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + DIV_W'(1);
    end

    always_comb begin
        tick_a = strobe(div_cnt, code_a);
        tick_b = strobe(div_cnt, code_b);
    end

    AST_SLOW_IN_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (code_a >= code_b) && tick_a |-> tick_b); // R2
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         join_req,
    input  logic [W-1:0] per_h,
    input  logic [W-1:0] per_l,
    input  logic [W-1:0] duty_h,
    input  logic [W-1:0] duty_l,
    output logic         out_h,
    output logic         out_l
);
    localparam int W2 = 2 * W;

    pair_mode_e   state, state_nx;
    logic [W-1:0] cnt_h, cnt_l, aper_h, aper_l, aduty_h, aduty_l;
    logic         switch_now, wrap_h, wrap_l, wrap_j;

    always_comb begin
        unique case (state)
            PAIR_SPLIT:  state_nx = join_req ? PAIR_JOINED : PAIR_SPLIT;
            PAIR_JOINED: state_nx = join_req ? PAIR_JOINED : PAIR_SPLIT;
            default:     state_nx = PAIR_SPLIT;
        endcase
        switch_now = (state_nx != state);
        wrap_h = tick && (cnt_h >= aper_h);
        wrap_l = tick && (cnt_l >= aper_l);
        wrap_j = tick && ({cnt_h, cnt_l} >= {aper_h, aper_l});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PAIR_SPLIT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_h <= '0;  cnt_l <= '0;
            aper_h <= '0; aper_l <= '0;
            aduty_h <= '0; aduty_l <= '0;
        end else if (switch_now) begin
            cnt_h <= '0;  cnt_l <= '0;
            aper_h <= per_h;   aper_l <= per_l;
            aduty_h <= duty_h; aduty_l <= duty_l;
        end else begin
            unique case (state)
                PAIR_SPLIT: begin
                    if (wrap_h) begin
                        cnt_h <= '0; aper_h <= per_h; aduty_h <= duty_h;
                    end else if (tick) begin
                        cnt_h <= cnt_h + W'(1);
                    end
                    if (wrap_l) begin
                        cnt_l <= '0; aper_l <= per_l; aduty_l <= duty_l;
                    end else if (tick) begin
                        cnt_l <= cnt_l + W'(1);
                    end
                end
                PAIR_JOINED: begin
                    if (wrap_j) begin
                        cnt_h <= '0;  cnt_l <= '0;
                        aper_h <= per_h;   aper_l <= per_l;
                        aduty_h <= duty_h; aduty_l <= duty_l;
                    end else if (tick) begin
                        {cnt_h, cnt_l} <= {cnt_h, cnt_l} + W2'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_h <= 1'b0;
            out_l <= 1'b0;
        end else begin
            unique case (state)
                PAIR_SPLIT: begin
                    out_h <= cnt_h < aduty_h;
                    out_l <= cnt_l < aduty_l;
                end
                PAIR_JOINED: begin
                    out_h <= {cnt_h, cnt_l} < {aduty_h, aduty_l};
                    out_l <= 1'b0;
                end
                default: begin
                    out_h <= 1'b0;
                    out_l <= 1'b0;
                end
            endcase
        end
    end

    AST_ODD_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PAIR_JOINED) && $past(state == PAIR_JOINED) |-> !out_l); // R6
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PAIR_SPLIT) |-> (cnt_h <= aper_h) && (cnt_l <= aper_l)); // R3
    AST_CNT16_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PAIR_JOINED) |-> ({cnt_h, cnt_l} <= {aper_h, aper_l})); // R5
    AST_HOLD_WORKING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PAIR_SPLIT) && !switch_now && !wrap_l |=> $stable(aduty_l) && $stable(aper_l)); // R7
    AST_RESTART_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        switch_now |=> (cnt_h == '0) && (cnt_l == '0)); // R8
endmodule

// File: rtl/pwm4_joinable.sv
module pwm4_joinable
    import pwm_pkg::*;
#(
    parameter int W      = 8,
    parameter int CODE_W = 3,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int JOIN_BIT0 = 2 * CODE_W;

    logic [W-1:0] ctrl_q;
    logic [W-1:0] per_q  [NUM_CH];
    logic [W-1:0] duty_q [NUM_CH];
    logic         tick_a, tick_b;
    logic [NUM_PAIRS-1:0] pair_tick;
    logic [NUM_PAIRS-1:0] pin_h, pin_l;

    pwm_regs #(.W(W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctrl_q(ctrl_q),
        .per_q(per_q), .duty_q(duty_q)
    );

    pwm_prescale #(.CODE_W(CODE_W)) u_div (
        .clk(clk), .rst_n(rst_n),
        .code_a(ctrl_q[2*CODE_W-1:CODE_W]),
        .code_b(ctrl_q[CODE_W-1:0]),
        .tick_a(tick_a), .tick_b(tick_b)
    );

    assign pair_tick = {tick_b, tick_a};

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        pwm_pair #(.W(W)) u_pair (
            .clk(clk), .rst_n(rst_n), .tick(pair_tick[p]),
            .join_req(ctrl_q[JOIN_BIT0 + p]),
            .per_h(per_q[2*p]),   .per_l(per_q[2*p+1]),
            .duty_h(duty_q[2*p]), .duty_l(duty_q[2*p+1]),
            .out_h(pin_h[p]), .out_l(pin_l[p])
        );
        assign pwm_out[2*p]   = pin_h[p];
        assign pwm_out[2*p+1] = pin_l[p];
    end

    AST_RESET_PINS_LOW: assert property (@(posedge clk)
        !rst_n |-> pwm_out == '0); // R9
endmodule

// File: tb/test_pwm4_joinable.sv
module test_pwm4_joinable;
    localparam int CLK_NS = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] pwm_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_NS / 2.0) clk = ~clk;

    pwm4_joinable i_pwm4_joinable (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    typedef struct packed {
        logic        joined;
        logic        pair;
        logic [2:0]  code;
        logic [15:0] per;   // split: low byte -> even ch, high byte -> odd ch
        logic [15:0] duty;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 3'd0, 16'h0509, 16'h0304},
        '{1'b0, 1'b1, 3'd1, 16'h0703, 16'h0002},
        '{1'b0, 1'b0, 3'd2, 16'h0406, 16'hC807},
        '{1'b1, 1'b0, 3'd0, 16'h012C, 16'h0096},
        '{1'b1, 1'b1, 3'd3, 16'h0105, 16'h0100},
        '{1'b1, 1'b1, 3'd0, 16'h0020, 16'h0000},
        '{1'b1, 1'b0, 3'd1, 16'h0003, 16'h0200},
        '{1'b0, 1'b1, 3'd7, 16'h0102, 16'h0101}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic count_high(input int pin, input int cycles, output int hi);
        hi = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out[pin]) hi++;
        end
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) @(negedge clk);
    endtask

    function automatic int steps_high(input int per, input int duty);
        return (duty < per + 1) ? duty : per + 1;
    endfunction

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        int v, hi, ev, od, ctrl, p_cyc, win;
        vec_t t;

        // Reset state: R9, R1
        idle(3);
        check("R9 pins low in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        rd(4'd0, v);  check("R1 control resets to zero", v, 0);
        rd(4'd6, v);  check("R1 period ch2 resets to zero", v, 0);
        check("R9 pins low after reset", int'(pwm_out), 0);

        // Register readback: R1
        wr(4'd0, 8'hA5); rd(4'd0, v); check("R1 control readback", v, 8'hA5);
        wr(4'd7, 8'h5A); rd(4'd7, v); check("R1 period ch3 readback", v, 8'h5A);
        wr(4'd9, 8'h3C); rd(4'd9, v); check("R1 duty ch1 readback", v, 8'h3C);
        rd(4'd15, v); check("R1 unmapped reads zero", v, 0);
        wr(4'd0, 8'h00);

        // Vector table: R2 R3 R4 R5 R6 R8
        for (int k = 0; k < NV; k++) begin
            t  = VECS[k];
            ev = 2 * int'(t.pair);
            od = ev + 1;
            if (t.joined) begin
                wr(4'(4 + ev), t.per[15:8]);  wr(4'(4 + od), t.per[7:0]);
                wr(4'(8 + ev), t.duty[15:8]); wr(4'(8 + od), t.duty[7:0]);
            end else begin
                wr(4'(4 + ev), t.per[7:0]);   wr(4'(4 + od), t.per[15:8]);
                wr(4'(8 + ev), t.duty[7:0]);  wr(4'(8 + od), t.duty[15:8]);
            end
            ctrl = t.pair ? int'(t.code) : (int'(t.code) << 3);
            if (t.joined) ctrl |= (t.pair ? 8'h80 : 8'h40);
            // toggle the join bit twice: R8 reload of working registers
            wr(4'd0, 8'(ctrl ^ (t.pair ? 8'h80 : 8'h40)));
            wr(4'd0, 8'(ctrl));
            if (t.joined) begin
                p_cyc = (int'(t.per) + 1) << t.code;
                idle(p_cyc + 10);
                win = 2 * p_cyc;
                count_high(ev, win, hi);
                check($sformatf("R5 R2 R4 joined vec %0d even pin", k), hi,
                      2 * (steps_high(int'(t.per), int'(t.duty)) << t.code));
                count_high(od, win, hi);
                check($sformatf("R6 joined vec %0d odd pin low", k), hi, 0);
            end else begin
                p_cyc = (int'(t.per[7:0]) + 1) << t.code;
                win   = (int'(t.per[15:8]) + 1) << t.code;
                idle(((p_cyc > win) ? p_cyc : win) + 10);
                count_high(ev, 2 * p_cyc, hi);
                check($sformatf("R3 R2 R4 split vec %0d even ch", k), hi,
                      2 * (steps_high(int'(t.per[7:0]), int'(t.duty[7:0])) << t.code));
                count_high(od, 2 * win, hi);
                check($sformatf("R3 R2 R4 split vec %0d odd ch", k), hi,
                      2 * (steps_high(int'(t.per[15:8]), int'(t.duty[15:8])) << t.code));
            end
        end

        // Deferred load: R7 (ch2 split, code 0, period 199, duty 10)
        wr(4'd6, 8'd199); wr(4'd10, 8'd10);
        wr(4'd0, 8'h80);  wr(4'd0, 8'h00);
        idle(20);
        wr(4'd10, 8'd150);
        count_high(2, 100, hi);
        check("R7 duty change held until wrap", hi, 0);
        idle(100);
        count_high(2, 400, hi);
        check("R7 new duty after wrap", hi, 300);

        // Reset while running: R9 R1
        wr(4'd0, 8'h40);
        wr(4'd4, 8'd0); wr(4'd5, 8'd9); wr(4'd8, 8'd0); wr(4'd9, 8'd200);
        idle(20);
        @(negedge clk); rst_n = 1'b0; #1;
        check("R9 pins low on mid-run reset", int'(pwm_out), 0);
        idle(2);
        rst_n = 1'b1;
        rd(4'd0, v); check("R1 control cleared by reset", v, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule